// File: doc/BRIEF.md
# Reset and Boot Sequencer

This block merges four chip reset sources into one internal reset for the processor and peripherals. The sources are an asynchronous power-on reset, an active-low external reset pin, a watchdog trip and a brownout trip. The three non-power-on sources pass through a synchronizer. The power-on reset acts asynchronously on every register in the block.

A three-state machine drives the internal reset:

- `SEQ_HOLD` keeps the reset active while any synchronized source is active. When all sources are quiet, the **quiet** transition moves it to `SEQ_COUNT`.
- `SEQ_COUNT` runs a wake-up counter. The counter advances only on clock edges where the oscillator-ready input is high. If a source reasserts, the **retrigger** transition returns to `SEQ_HOLD` and the count starts over from zero. When the last count is reached, the **expire** transition enters `SEQ_RUN` and releases the reset.
- `SEQ_RUN` is normal operation. Any source takes the **trip** transition back to `SEQ_HOLD`.

A power-on reset also arms a strap capture. On the expire edge that ends a power-on episode, two strap inputs are decoded into a shared data-bus width for external memory banks 0 and 1. The code that starts executing from bank 1 depends on that width.

Power-on reset also sets a flag saying that the address ranges of chip selects 0 and 1 are swapped. Software clears this flag.

A sticky cause register records which sources caused resets. Software clears it bit by bit with write-one-to-clear.

Top module: `reset_boot_ctrl`

## Requirements
- R1: `core_rst_n` goes low asynchronously when `por` is high. It also goes low on the (SYNC_STAGES+1)-th rising edge after `ext_rst_n` falls, `wdt_rst` rises or `bod_rst` rises. It stays low while any of them remains active.
- R2: Let d be the last cycle in which a source is active, with `osc_ready` held high. For a synchronized source, `core_rst_n` rises on edge d+SYNC_STAGES+1+WAKE_CYCLES. When `por` is deasserted before edge c+1, `core_rst_n` rises on edge c+1+WAKE_CYCLES.
- R3: A source that reasserts while the wake-up count is running abandons the count. The full WAKE_CYCLES count starts again after that source is released.
- R4: Each edge in `SEQ_COUNT` with `osc_ready` low leaves the count unchanged. A low period of k edges delays the release by exactly k cycles and does not restart the count.
- R5: `bus_width` encodes 0 = 8-bit, 1 = 16-bit, 2 = 32-bit. It reads 0 while `por` is high. On the release edge that ends a power-on episode it loads the decode of `boot_strap`: 00 gives 0, 01 gives 1, 10 gives 2, and 11 (reserved) gives 0.
- R6: A release that ends an episode containing no power-on reset leaves `bus_width` unchanged, whatever `boot_strap` is.
- R7: `cs_swap` reads 1 while `por` is high and stays 1 afterwards. A one-cycle `sw_swap_clr` makes it 0 from the next edge. Resets from the external pin, the watchdog or the brownout leave it unchanged.
- R8: `rst_cause` bit 0 means power-on, bit 1 the external pin, bit 2 the watchdog and bit 3 the brownout. `por` forces the register to 0001. Each other bit is set on the (SYNC_STAGES+1)-th edge after its source asserts and stays set after the source is released.
- R9: When `sw_cause_clr_we` is high at an edge, each bit of `rst_cause` whose `sw_cause_clr_mask` bit is 1 is cleared at that edge. The exception is a bit whose synchronized source is still active at that edge: the set wins and the bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por | input | 1 | Power-on reset, active high, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low |
| wdt_rst | input | 1 | Watchdog reset request, active high |
| bod_rst | input | 1 | Brownout reset request, active high |
| osc_ready | input | 1 | Oscillator running indication |
| boot_strap | input | 2 | Boot strap pins selecting bus width |
| sw_cause_clr_we | input | 1 | Strobe for cause-register clear |
| sw_cause_clr_mask | input | 4 | Bits of the cause register to clear |
| sw_swap_clr | input | 1 | Strobe that clears the chip-select swap flag |
| core_rst_n | output | 1 | Internal reset, active low |
| bus_width | output | 2 | Shared data-bus width for banks 0 and 1 |
| cs_swap | output | 1 | Chip-select 0/1 address swap active |
| rst_cause | output | 4 | Sticky record of reset sources |

## Verification
Each result falls due a fixed number of cycles after its stimulus:

- **Source entry:** a synchronized source reaches `core_rst_n` and `rst_cause` SYNC_STAGES+1 edges after it changes.
- **Release:** `core_rst_n` rises WAKE_CYCLES edges after `SEQ_COUNT` is entered, plus one edge for every edge with `osc_ready` low.
- **Strap width:** `bus_width` changes on the same edge as the release.
- **Software writes:** the effect of a software write appears on the next edge.

The bench computes each due cycle from these rules and pushes the expected value, tagged with that cycle, into a queue kept in cycle order. A monitor samples on the falling clock edge and compares only the entries whose cycle has arrived. For the release times it also checks the cycle before, so a release one cycle early is reported. Any entry still in the queue at the end counts as a failure.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        SEQ_HOLD  = 2'd0,
        SEQ_COUNT = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_t;

    // External memory data bus width code
    typedef enum logic [1:0] {
        BW_8  = 2'd0,
        BW_16 = 2'd1,
        BW_32 = 2'd2
    } bus_width_t;

    // Strap decode; the reserved code falls back to the narrowest bus
    function automatic bus_width_t strap_to_width(input logic [1:0] strap);
        bus_width_t w;
        case (strap)
            2'b01:   w = BW_16;
            2'b10:   w = BW_32;
            default: w = BW_8;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_async,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int DEPTH = (STAGES < 1) ? 1 : STAGES;

    logic [DEPTH-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or posedge rst_async) begin
        if (rst_async) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d;
            for (int s = 1; s < DEPTH; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q = chain_q[DEPTH-1];

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int WAKE_CYCLES = 4096,
    parameter int NSRC        = 3
) (
    input  logic            clk,
    input  logic            por,
    input  logic [NSRC-1:0] src_active,
    input  logic            osc_ready,
    output logic            release_now,
    output logic            core_rst_n
);
    localparam int CNT_W = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_CYCLES - 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             any_src;
    logic             rst_n_q;

    assign any_src = |src_active;

    // Next-state and wake-up counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SEQ_HOLD: begin
                cnt_d = '0;
                if (!any_src) begin
                    state_d = SEQ_COUNT;          // quiet
                end
            end
            SEQ_COUNT: begin
                if (any_src) begin
                    state_d = SEQ_HOLD;           // retrigger
                    cnt_d   = '0;
                end else if (osc_ready) begin
                    if (cnt_q == CNT_LAST) begin
                        state_d = SEQ_RUN;        // expire
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            SEQ_RUN: begin
                if (any_src) begin
                    state_d = SEQ_HOLD;           // trip
                end
            end
            default: begin
                state_d = SEQ_HOLD;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            state_q <= SEQ_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output register
    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            rst_n_q <= 1'b0;
        end else begin
            rst_n_q <= (state_d == SEQ_RUN);
        end
    end

    assign core_rst_n  = rst_n_q;
    assign release_now = (state_q == SEQ_COUNT) && (state_d == SEQ_RUN);

    // R1: an active synchronized source keeps the reset asserted
    p_src_forces_reset_r1: assert property (@(posedge clk) disable iff (por)
        any_src |=> !core_rst_n);

    // R2: counter stays inside its window
    p_count_bound_r2: assert property (@(posedge clk) disable iff (por)
        cnt_q <= CNT_LAST);

    // R4: release only after a counted edge with the oscillator ready
    p_release_needs_osc_r4: assert property (@(posedge clk) disable iff (por)
        $rose(core_rst_n) |-> $past(osc_ready));

endmodule

// File: rtl/rstseq_boot_cfg.sv
module rstseq_boot_cfg
    import rstseq_pkg::*;
#(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            por,
    input  logic            release_now,
    input  logic [1:0]      boot_strap,
    input  logic [NSRC-1:0] src_active,
    input  logic            clr_we,
    input  logic [NSRC:0]   clr_mask,
    input  logic            swap_clr,
    output bus_width_t      width,
    output logic            cs_swap,
    output logic [NSRC:0]   cause
);
    logic       boot_pending_q;
    bus_width_t width_q;
    logic       swap_q;
    logic [NSRC:0] cause_q;

    // Power-on episode marker: arms the strap capture
    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            boot_pending_q <= 1'b1;
        end else if (release_now) begin
            boot_pending_q <= 1'b0;
        end
    end

    // Strap capture on the release edge of a power-on episode
    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            width_q <= BW_8;
        end else if (release_now && boot_pending_q) begin
            width_q <= strap_to_width(boot_strap);
        end
    end

    // Chip-select swap flag
    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            swap_q <= 1'b1;
        end else if (swap_clr) begin
            swap_q <= 1'b0;
        end
    end

    // Cause bit 0: power-on
    logic por_bit_q;
    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            por_bit_q <= 1'b1;
        end else if (clr_we && clr_mask[0]) begin
            por_bit_q <= 1'b0;
        end
    end
    assign cause_q[0] = por_bit_q;

    // Cause bits for the synchronized sources; set wins over clear
    for (genvar i = 1; i <= NSRC; i++) begin : g_cause
        logic bit_q;
        always_ff @(posedge clk or posedge por) begin
            if (por) begin
                bit_q <= 1'b0;
            end else if (src_active[i-1]) begin
                bit_q <= 1'b1;
            end else if (clr_we && clr_mask[i]) begin
                bit_q <= 1'b0;
            end
        end
        assign cause_q[i] = bit_q;
    end

    assign width   = width_q;
    assign cs_swap = swap_q;
    assign cause   = cause_q;

    // R6: width moves only on a release edge
    p_width_hold_r6: assert property (@(posedge clk) disable iff (por)
        !release_now |=> $stable(width_q));

    // R7: only power-on reset can set the swap flag
    p_swap_no_self_set_r7: assert property (@(posedge clk) disable iff (por)
        !$rose(swap_q));

    // R8: the power-on cause bit is never set outside power-on reset
    p_por_bit_only_por_r8: assert property (@(posedge clk) disable iff (por)
        !$rose(cause_q[0]));

endmodule

// File: rtl/reset_boot_ctrl.sv
module reset_boot_ctrl
    import rstseq_pkg::*;
#(
    parameter int WAKE_CYCLES = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por,
    input  logic       ext_rst_n,
    input  logic       wdt_rst,
    input  logic       bod_rst,
    input  logic       osc_ready,
    input  logic [1:0] boot_strap,
    input  logic       sw_cause_clr_we,
    input  logic [3:0] sw_cause_clr_mask,
    input  logic       sw_swap_clr,
    output logic       core_rst_n,
    output logic [1:0] bus_width,
    output logic       cs_swap,
    output logic [3:0] rst_cause
);
    localparam int NSRC = 3;

    logic [NSRC-1:0] src_raw;
    logic [NSRC-1:0] src_sync;
    logic            release_now;
    bus_width_t      width;

    // Active-high source vector: [0] pin, [1] watchdog, [2] brownout
    assign src_raw = {bod_rst, wdt_rst, ~ext_rst_n};

    rstseq_sync #(
        .WIDTH  (NSRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_async (por),
        .d         (src_raw),
        .q         (src_sync)
    );

    rstseq_fsm #(
        .WAKE_CYCLES (WAKE_CYCLES),
        .NSRC        (NSRC)
    ) u_fsm (
        .clk         (clk),
        .por         (por),
        .src_active  (src_sync),
        .osc_ready   (osc_ready),
        .release_now (release_now),
        .core_rst_n  (core_rst_n)
    );

    rstseq_boot_cfg #(
        .NSRC (NSRC)
    ) u_cfg (
        .clk         (clk),
        .por         (por),
        .release_now (release_now),
        .boot_strap  (boot_strap),
        .src_active  (src_sync),
        .clr_we      (sw_cause_clr_we),
        .clr_mask    (sw_cause_clr_mask),
        .swap_clr    (sw_swap_clr),
        .width       (width),
        .cs_swap     (cs_swap),
        .cause       (rst_cause)
    );

    assign bus_width = width;

endmodule

// File: tb/sim_reset_boot_ctrl.sv
module sim_reset_boot_ctrl;
    localparam int W    = 12;
    localparam int SYNC = 2;
    localparam int LAT  = SYNC + 1;

    localparam int K_RST   = 0;
    localparam int K_WIDTH = 1;
    localparam int K_SWAP  = 2;
    localparam int K_CAUSE = 3;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       ext_rst_n = 1'b1;
    logic       wdt_rst = 1'b0;
    logic       bod_rst = 1'b0;
    logic       osc_ready = 1'b1;
    logic [1:0] boot_strap = 2'b10;
    logic       sw_cause_clr_we = 1'b0;
    logic [3:0] sw_cause_clr_mask = 4'b0000;
    logic       sw_swap_clr = 1'b0;
    logic       core_rst_n;
    logic [1:0] bus_width;
    logic       cs_swap;
    logic [3:0] rst_cause;

    int cyc = 0;
    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    typedef struct {
        int    at;
        int    kind;
        int    val;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    reset_boot_ctrl #(
        .WAKE_CYCLES (W),
        .SYNC_STAGES (SYNC)
    ) u0 (
        .clk               (clk),
        .por               (por),
        .ext_rst_n         (ext_rst_n),
        .wdt_rst           (wdt_rst),
        .bod_rst           (bod_rst),
        .osc_ready         (osc_ready),
        .boot_strap        (boot_strap),
        .sw_cause_clr_we   (sw_cause_clr_we),
        .sw_cause_clr_mask (sw_cause_clr_mask),
        .sw_swap_clr       (sw_swap_clr),
        .core_rst_n        (core_rst_n),
        .bus_width         (bus_width),
        .cs_swap           (cs_swap),
        .rst_cause         (rst_cause)
    );

    // Driver side: queue an expected value for a given cycle, kept sorted
    task automatic expect_at(input int at, input int kind, input int val, input string tag);
        exp_t item;
        int   idx;
        item.at   = at;
        item.kind = kind;
        item.val  = val;
        item.tag  = tag;
        idx = sb.size();
        for (int i = 0; i < sb.size(); i++) begin
            if (sb[i].at > at) begin
                idx = i;
                break;
            end
        end
        sb.insert(idx, item);
    endtask

    task automatic at_cycle(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Monitor: compare due entries on the falling edge
    always @(negedge clk) begin
        exp_t  e;
        int    act;
        string name;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            e = sb.pop_front();
            case (e.kind)
                K_RST:   begin act = int'(core_rst_n); name = "core_rst_n"; end
                K_WIDTH: begin act = int'(bus_width);  name = "bus_width";  end
                K_SWAP:  begin act = int'(cs_swap);    name = "cs_swap";    end
                default: begin act = int'(rst_cause);  name = "rst_cause";  end
            endcase
            checks++;
            if (act != e.val) begin
                errors++;
                $display("FAIL %s %s at cycle %0d: actual %0d expected %0d",
                         e.tag, name, cyc, act, e.val);
            end
        end
    end

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        int t;
        int d;
        int e;
        repeat (3) @(negedge clk);

        // Power-on reset with strap 10
        t = cyc;
        expect_at(t + 1, K_RST, 0, "R1");
        expect_at(t + 1, K_SWAP, 1, "R7");
        expect_at(t + 1, K_CAUSE, 1, "R8");
        expect_at(t + 1, K_WIDTH, 0, "R5");
        por = 1'b0;
        expect_at(t + W, K_RST, 0, "R2");
        expect_at(t + W + 1, K_RST, 1, "R2");
        expect_at(t + W + 1, K_WIDTH, 2, "R5");
        at_cycle(t + W + 3);

        // Software clears swap flag
        t = cyc;
        sw_swap_clr = 1'b1;
        expect_at(t + 1, K_SWAP, 0, "R7");
        @(negedge clk);
        sw_swap_clr = 1'b0;

        // Write-one-to-clear of the power-on bit
        t = cyc;
        sw_cause_clr_we = 1'b1;
        sw_cause_clr_mask = 4'b0001;
        expect_at(t + 1, K_CAUSE, 0, "R9");
        @(negedge clk);
        sw_cause_clr_we = 1'b0;

        // Watchdog reset: width and swap held
        boot_strap = 2'b01;
        t = cyc;
        wdt_rst = 1'b1;
        expect_at(t + 2, K_RST, 1, "R1");
        expect_at(t + 3, K_RST, 0, "R1");
        expect_at(t + 3, K_CAUSE, 4, "R8");
        at_cycle(t + 5);
        wdt_rst = 1'b0;
        d = t + 5;
        expect_at(d + LAT + W - 1, K_RST, 0, "R2");
        expect_at(d + LAT + W, K_RST, 1, "R2");
        expect_at(d + LAT + W, K_WIDTH, 2, "R6");
        expect_at(d + LAT + W, K_SWAP, 0, "R7");
        at_cycle(d + LAT + W + 2);

        // Brownout; clear while active (set wins), then clear after release
        t = cyc;
        bod_rst = 1'b1;
        expect_at(t + 3, K_CAUSE, 12, "R8");
        at_cycle(t + 4);
        sw_cause_clr_we = 1'b1;
        sw_cause_clr_mask = 4'b1111;
        expect_at(t + 5, K_CAUSE, 8, "R9");
        @(negedge clk);
        sw_cause_clr_we = 1'b0;
        at_cycle(t + 6);
        bod_rst = 1'b0;
        d = t + 6;
        at_cycle(d + 3);
        sw_cause_clr_we = 1'b1;
        sw_cause_clr_mask = 4'b1000;
        expect_at(d + 4, K_CAUSE, 0, "R9");
        expect_at(d + LAT + W, K_RST, 1, "R2");
        @(negedge clk);
        sw_cause_clr_we = 1'b0;
        at_cycle(d + LAT + W + 2);

        // Pin pulse, then a second pulse during the count restarts it
        t = cyc;
        ext_rst_n = 1'b0;
        expect_at(t + 3, K_CAUSE, 2, "R8");
        @(negedge clk);
        ext_rst_n = 1'b1;
        at_cycle(t + 9);
        e = t + 9;
        ext_rst_n = 1'b0;
        @(negedge clk);
        ext_rst_n = 1'b1;
        expect_at(t + 4 + W, K_RST, 0, "R3");
        expect_at(e + 3 + W, K_RST, 0, "R3");
        expect_at(e + 4 + W, K_RST, 1, "R3");
        at_cycle(e + W + 6);

        // Oscillator drop for 7 edges during the count
        t = cyc;
        wdt_rst = 1'b1;
        @(negedge clk);
        wdt_rst = 1'b0;
        at_cycle(t + 7);
        osc_ready = 1'b0;
        at_cycle(t + 14);
        osc_ready = 1'b1;
        expect_at(t + 4 + W + 6, K_RST, 0, "R4");
        expect_at(t + 4 + W + 7, K_RST, 1, "R4");
        at_cycle(t + W + 14);

        // Power-on with reserved strap 11
        boot_strap = 2'b11;
        t = cyc;
        por = 1'b1;
        expect_at(t + 1, K_RST, 0, "R1");
        expect_at(t + 1, K_SWAP, 1, "R7");
        expect_at(t + 1, K_CAUSE, 1, "R8");
        at_cycle(t + 3);
        por = 1'b0;
        d = t + 3;
        expect_at(d + 1 + W, K_WIDTH, 0, "R5");
        expect_at(d + 1 + W, K_RST, 1, "R2");
        at_cycle(d + W + 3);

        // Power-on with strap 01
        boot_strap = 2'b01;
        t = cyc;
        por = 1'b1;
        expect_at(t + 1, K_WIDTH, 0, "R5");
        at_cycle(t + 3);
        por = 1'b0;
        d = t + 3;
        expect_at(d + 1 + W, K_WIDTH, 1, "R5");
        at_cycle(d + W + 4);

        if (sb.size() > 0) begin
            foreach (sb[i]) begin
                checks++;
                errors++;
                $display("FAIL %s unchecked entry: actual none expected %0d", sb[i].tag, sb[i].val);
            end
        end
        if (!finished) begin
            finished = 1'b1;
            report();
        end
    end

endmodule